// File: doc/BRIEF.md
# Oscillator Drift Trim Tick Generator

This block turns a nominal 32768 Hz enable pulse into a one-second tick whose average rate can be nudged by a programmed number of parts per billion. A 16-bit trim word carries a signed step count and a resolution selector. Over a fixed window of input pulses the block either swallows a few pulses, so that ticks come later, or counts a few pulses twice, so that ticks come sooner. The adjustments are spread evenly across the window rather than bunched together.

A written trim word is held as pending and takes over only when the current window closes. The tick period stays the same for whole windows, so software can change the trim at any moment without a partial correction.

The fine resolution uses a window of 2^20 input pulses, which is about 954 ppb per step. The coarse resolution uses a window of 2^18 pulses, which is about 3815 ppb per step. Each window is cut into 256 equal slots. An adjustment lands on the first pulse of each of the first |value| slots.

Top module: `trim_tick_gen`

## Requirements
- R1: `tick_o` is a one-cycle pulse that rises only in the cycle after a clock edge at which `en_i` was high.
- R2: With no correction active, one tick is produced for every DIV enable pulses (DIV defaults to 32768).
- R3: A trim word is valid only when bits 14:8 equal 7'b0100000 if bit 7 is 0, or 7'b0011111 if bit 7 is 1. An invalid word causes no correction for the whole window in which it is active.
- R4: Bits 7:0 are a two's-complement step count from -128 to +127, and the number of adjustments per window equals its magnitude (a count of -128 gives 128).
- R5: A positive step count swallows the enable pulse at each adjustment, so that pulse adds nothing to the tick count.
- R6: A negative step count makes each adjustment pulse add two to the tick count.
- R7: With bit 15 = 0 (fine), a correction window lasts 2^FINE_WIN_LOG enable pulses.
- R8: With bit 15 = 1 (coarse), a correction window lasts 2^COARSE_WIN_LOG enable pulses.
- R9: A window is split into 256 slots of equal length. An adjustment happens on the first enable pulse of slot k for every k below the magnitude.
- R10: A write updates only the pending word. The active trim changes only on the last enable pulse of a window, and it takes the value pending at that moment. A later write in the same window replaces an earlier one.
- R11: Reset clears the tick. It starts a fine window with no correction and sets the pending word to 16'h2000, which is valid with a step count of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | One-cycle enable at the nominal oscillator rate |
| wr_i | input | 1 | Write strobe for the pending trim word |
| wdata_i | input | 16 | Trim word: [15] resolution, [14:8] sign pattern, [7:0] step count |
| tick_o | output | 1 | Corrected one-second tick, registered |

## Verification
The assertions assume that `en_i` is a clean single-cycle strobe that is never wider than one clock. They also assume that DIV is at least 3, so that a doubled pulse can carry the count past DIV by at most one. The bench drives enable pulses on every other clock, issues writes only in cycles without an enable, and shrinks DIV and both window sizes so that whole windows at each resolution fit in a short run. The step counts it uses include the extremes -128 and +127, a zero count, two invalid sign patterns, and writes placed in the middle of a window.

// File: rtl/trim_pkg.sv
package trim_pkg;

  localparam int CFG_W       = 16;
  localparam int MAG_W       = 8;
  localparam int SLOT_LOG    = 8;
  localparam int PAT_W       = 7;
  localparam int MODE_BIT    = 15;
  localparam int SIGN_BIT    = 7;

  localparam logic [PAT_W-1:0] PAT_POS = 7'b0100000;
  localparam logic [PAT_W-1:0] PAT_NEG = 7'b0011111;
  localparam logic [CFG_W-1:0] NOMINAL_WORD = 16'h2000;

  typedef struct packed {
    logic             valid;
    logic             fast;
    logic             coarse;
    logic [MAG_W-1:0] mag;
  } trim_cfg_t;

endpackage

// File: rtl/trim_cfg_decode.sv
module trim_cfg_decode
  import trim_pkg::*;
(
  input  logic [CFG_W-1:0] word_i,
  output trim_cfg_t        cfg_o
);

  logic             neg;
  logic [PAT_W-1:0] want_pat;
  logic [MAG_W-1:0] raw;

  always_comb begin
    neg      = word_i[SIGN_BIT];
    raw      = word_i[MAG_W-1:0];
    want_pat = neg ? PAT_NEG : PAT_POS;
    cfg_o.valid  = (word_i[MODE_BIT-1 -: PAT_W] == want_pat);
    cfg_o.fast   = neg;
    cfg_o.coarse = word_i[MODE_BIT];
    cfg_o.mag    = neg ? (~raw + 1'b1) : raw;
  end

endmodule

// File: rtl/trim_window_seq.sv
module trim_window_seq
  import trim_pkg::*;
#(
  parameter int FINE_WIN_LOG   = 20,
  parameter int COARSE_WIN_LOG = 18
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en_i,
  input  trim_cfg_t nxt_cfg_i,
  output trim_cfg_t act_cfg_o,
  output logic      wrap_o,
  output logic      adj_req_o,
  output logic      adj_fast_o
);

  localparam int FINE_OFS   = FINE_WIN_LOG - SLOT_LOG;
  localparam int COARSE_OFS = COARSE_WIN_LOG - SLOT_LOG;

  logic [FINE_WIN_LOG-1:0] win_q;
  trim_cfg_t               act_q;
  logic [SLOT_LOG-1:0]     slot_idx;
  logic                    slot_head;
  logic                    fine_end;
  logic                    coarse_end;

  always_comb begin
    fine_end   = (win_q == '1);
    coarse_end = (win_q[COARSE_WIN_LOG-1:0] == '1);
    if (act_q.coarse) begin
      slot_idx  = win_q[COARSE_WIN_LOG-1 -: SLOT_LOG];
      slot_head = (win_q[COARSE_OFS-1:0] == '0);
      wrap_o    = coarse_end;
    end else begin
      slot_idx  = win_q[FINE_WIN_LOG-1 -: SLOT_LOG];
      slot_head = (win_q[FINE_OFS-1:0] == '0);
      wrap_o    = fine_end;
    end
    adj_req_o  = act_q.valid && slot_head &&
                 ({1'b0, slot_idx} < {1'b0, act_q.mag});
    adj_fast_o = act_q.fast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
      act_q <= '0;
    end else if (en_i) begin
      if (wrap_o) begin
        win_q <= '0;
        act_q <= nxt_cfg_i;
      end else begin
        win_q <= win_q + 1'b1;
      end
    end
  end

  assign act_cfg_o = act_q;

endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler #(
  parameter int DIV   = 32768,
  parameter int CNT_W = $clog2(DIV + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             adj_req_i,
  input  logic             adj_fast_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);

  localparam logic [CNT_W-1:0] DIV_C = CNT_W'(DIV);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] sum;
  logic             tick_q;

  always_comb begin
    if (adj_req_i) step = adj_fast_i ? CNT_W'(2) : CNT_W'(0);
    else           step = CNT_W'(1);
    sum = cnt_q + step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (en_i) begin
      if (sum >= DIV_C) begin
        cnt_q  <= sum - DIV_C;
        tick_q <= 1'b1;
      end else begin
        cnt_q  <= sum;
        tick_q <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;

endmodule

// File: rtl/trim_tick_gen.sv
module trim_tick_gen
  import trim_pkg::*;
#(
  parameter int DIV            = 32768,
  parameter int FINE_WIN_LOG   = 20,
  parameter int COARSE_WIN_LOG = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             tick_o
);

  localparam int CNT_W = $clog2(DIV + 2);

  logic [CFG_W-1:0] pend_q;
  trim_cfg_t        nxt_cfg;
  trim_cfg_t        act_cfg;
  logic             wrap;
  logic             adj_req;
  logic             adj_fast;
  logic [CNT_W-1:0] pre_cnt;

  always_ff @(posedge clk) begin
    if (rst)       pend_q <= NOMINAL_WORD;
    else if (wr_i) pend_q <= wdata_i;
  end

  trim_cfg_decode u_dec (
    .word_i (pend_q),
    .cfg_o  (nxt_cfg)
  );

  trim_window_seq #(
    .FINE_WIN_LOG   (FINE_WIN_LOG),
    .COARSE_WIN_LOG (COARSE_WIN_LOG)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .nxt_cfg_i  (nxt_cfg),
    .act_cfg_o  (act_cfg),
    .wrap_o     (wrap),
    .adj_req_o  (adj_req),
    .adj_fast_o (adj_fast)
  );

  trim_prescaler #(
    .DIV   (DIV),
    .CNT_W (CNT_W)
  ) u_pre (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .adj_req_i  (adj_req),
    .adj_fast_i (adj_fast),
    .cnt_o      (pre_cnt),
    .tick_o     (tick_o)
  );

endmodule

// File: rtl/trim_tick_gen_chk.sv
module trim_tick_gen_chk
  import trim_pkg::*;
#(
  parameter int DIV   = 32768,
  parameter int CNT_W = $clog2(DIV + 2)
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             tick_o,
  input trim_cfg_t        act_cfg,
  input logic             wrap,
  input logic             adj_req,
  input logic             adj_fast,
  input logic [CNT_W-1:0] pre_cnt
);

  // R1: a tick only follows an accepted enable
  a_r1_tick_after_en: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(en_i));

  // R11: reset leaves the tick low
  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !tick_o);

  // R2: the prescaler never holds a count at or above DIV
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    pre_cnt < CNT_W'(DIV));

  // R3: no adjustment while the active word is invalid
  a_r3_invalid_idle: assert property (@(posedge clk) disable iff (rst)
    !act_cfg.valid |-> !adj_req);

  // R5: a swallowed pulse leaves the count unchanged and gives no tick
  a_r5_swallow: assert property (@(posedge clk) disable iff (rst)
    (en_i && adj_req && !adj_fast) |=> (pre_cnt == $past(pre_cnt)) && !tick_o);

  // R6: a doubled pulse below the limit adds exactly two
  a_r6_double: assert property (@(posedge clk) disable iff (rst)
    (en_i && adj_req && adj_fast && (pre_cnt < CNT_W'(DIV - 2)))
      |=> pre_cnt == $past(pre_cnt) + CNT_W'(2));

  // R10: the active trim only moves at a window end
  a_r10_cfg_held: assert property (@(posedge clk) disable iff (rst)
    !(en_i && wrap) |=> $stable(act_cfg));

endmodule

bind trim_tick_gen trim_tick_gen_chk #(.DIV(DIV)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en_i     (en_i),
  .tick_o   (tick_o),
  .act_cfg  (act_cfg),
  .wrap     (wrap),
  .adj_req  (adj_req),
  .adj_fast (adj_fast),
  .pre_cnt  (pre_cnt)
);

// File: tb/tb_trim_tick_gen.sv
module tb_trim_tick_gen;

  localparam int DIV = 16;
  localparam int FW  = 10;
  localparam int CW  = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic        tick_o;

  trim_tick_gen #(.DIV(DIV), .FINE_WIN_LOG(FW), .COARSE_WIN_LOG(CW)) dut (
    .clk(clk), .rst(rst), .en_i(en_i), .wr_i(wr_i), .wdata_i(wdata_i), .tick_o(tick_o)
  );

  always #10 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  int    en_idx = 0;
  int    exp_q[$];
  int    exp_ph = 0;
  int    obs_ph = 0;
  string cur_req = "R11";

  // reference model state, built from the requirements
  int          m_win = 0;
  int          m_pre = 0;
  int          m_mag = 0;
  bit          m_valid = 0;
  bit          m_fast = 0;
  bit          m_coarse = 0;
  logic [15:0] m_pend = 16'h2000;

  task automatic load_act(input logic [15:0] v);
    m_valid  = (v[14:8] == (v[7] ? 7'b0011111 : 7'b0100000));
    m_fast   = v[7];
    m_coarse = v[15];
    m_mag    = v[7] ? 256 - int'(v[7:0]) : int'(v[7:0]);
  endtask

  task automatic run_en(input int n);
    for (int i = 0; i < n; i++) begin
      int wl, ivl, inc;
      @(negedge clk);
      en_idx++;
      wl  = m_coarse ? CW : FW;
      ivl = 1 << (wl - 8);
      inc = 1;
      if (m_valid && (m_win % ivl == 0) && (m_win / ivl < m_mag))
        inc = m_fast ? 2 : 0;
      m_pre += inc;
      if (m_pre >= DIV) begin
        m_pre -= DIV;
        exp_q.push_back(en_idx);
        exp_ph++;
      end
      if (m_win == (1 << wl) - 1) begin
        m_win = 0;
        load_act(m_pend);
      end else begin
        m_win++;
      end
      en_i = 1'b1;
      @(negedge clk);
      en_i = 1'b0;
    end
  endtask

  task automatic wr(input logic [15:0] v);
    wr_i    = 1'b1;
    wdata_i = v;
    m_pend  = v;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic end_phase();
    repeat (3) @(negedge clk);
    total++;
    if (obs_ph != exp_ph || exp_q.size() != 0) begin
      bad++;
      $display("FAIL %s phase tick count actual=%0d expected=%0d left=%0d",
               cur_req, obs_ph, exp_ph, exp_q.size());
    end
    exp_q.delete();
    obs_ph = 0;
    exp_ph = 0;
  endtask

  // monitor: compare each tick (or missing tick) against the queue
  always @(posedge clk) begin
    #5;
    if (!rst && !done) begin
      if (tick_o) begin
        obs_ph++;
        total++;
        if (exp_q.size() == 0 || !en_i || exp_q[0] != en_idx) begin
          bad++;
          $display("FAIL %s tick at enable actual=%0d expected=%0d", cur_req, en_idx,
                   (exp_q.size() > 0) ? exp_q[0] : -1);
        end
        if (exp_q.size() > 0 && exp_q[0] == en_idx) void'(exp_q.pop_front());
      end else if (en_i && exp_q.size() > 0 && exp_q[0] == en_idx) begin
        total++;
        bad++;
        $display("FAIL %s missing tick actual=0 expected=1 at enable %0d", cur_req, en_idx);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: tick low while and after reset
    total++;
    if (tick_o !== 1'b0) begin
      bad++;
      $display("FAIL R11 tick in reset actual=%b expected=0", tick_o);
    end
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (tick_o !== 1'b0) begin
      bad++;
      $display("FAIL R11 tick after reset actual=%b expected=0", tick_o);
    end

    // R2 R7: nominal, one fine window gives DIV-period ticks (1024/16 = 64)
    cur_req = "R2";
    run_en(1024);
    total++;
    if (exp_ph != 64) begin
      bad++;
      $display("FAIL R2 nominal model count actual=%0d expected=64", exp_ph);
    end
    end_phase();

    // R4 R5 R9: +16 fine, pulses swallowed
    cur_req = "R5";
    wr(16'h2010);
    run_en(2048);
    end_phase();

    // R6: -16 fine, pulses doubled
    cur_req = "R6";
    wr(16'h1FF0);
    run_en(2048);
    end_phase();

    // R8 R4: coarse -128, 128 doubles per 512-pulse window
    cur_req = "R8";
    wr(16'h9F80);
    run_en(1536);
    end_phase();

    // R8 R5: coarse +127
    cur_req = "R8";
    wr(16'hA07F);
    run_en(1024);
    end_phase();

    // R3: invalid patterns give no correction
    cur_req = "R3";
    wr(16'h0040);
    run_en(1024);
    wr(16'h1F10);
    run_en(1024);
    end_phase();

    // R10: mid-window writes, last one wins at the next window
    cur_req = "R10";
    wr(16'h2005);
    run_en(300);
    wr(16'h1F80);
    run_en(200);
    wr(16'h1FFD);
    run_en(1600);
    end_phase();

    // R1 R9: fine +127 for one window and a zero count
    cur_req = "R9";
    wr(16'h207F);
    run_en(1100);
    wr(16'h2000);
    run_en(1100);
    end_phase();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog run hung actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule